// File: doc/BRIEF.md
# Receive Squelch Timing Qualifier

This block decides when a twisted-pair receive line carries real data rather than impulse noise. Four comparator flags feed it: positive and negative polarity crossings, each at a normal and at a reduced threshold. While idle it watches the normal-threshold flags. A candidate starts with the first crossing of either polarity. The opposite polarity must then follow within a bounded window. After that, the starting polarity must return within a second window of the same length. Only when all three steps have completed does the block raise its data-valid output.

While data is valid the block switches the front end to the reduced thresholds and watches only the reduced-threshold flags. A brief dip in amplitude then cannot end the packet early. Data-valid drops once the reduced flags have been silent for longer than the end-of-packet timeout, and the thresholds go back to normal. A separate configuration input asks the front end for a lowered threshold set, for long cable runs. The block passes that request through on its select output.

The clock is 100 MHz. Both windows default to 15 cycles (150 ns) and the end-of-packet timeout defaults to 20 cycles (200 ns). All three are parameters.

Top module: `squelch_qualifier`

## Requirements
- R1: While idle, only the normal-threshold flags (`pos_hi_i`, `neg_hi_i`) can start a candidate. Reduced-threshold flags alone leave `data_valid_o` low. The first normal crossing sets the reference polarity. When both polarities are seen in the same cycle, positive is taken as the reference.
- R2: Let the candidate start at clock edge t. The opposite-polarity normal flag must be sampled at one of the edges t+1 to t+WIN_CYC. If it is not, the candidate is dropped at edge t+WIN_CYC.
- R3: Let the opposite crossing be accepted at edge u. The reference-polarity normal flag must be sampled at one of the edges u+1 to u+WIN_CYC. If it is not, the candidate is dropped at edge u+WIN_CYC.
- R4: `data_valid_o` goes high right after the edge that accepts the third step, and never before all three steps have completed.
- R5: While valid, every sampled reduced-threshold crossing (`pos_lo_i` or `neg_lo_i`) restarts the silence count. `data_valid_o` falls after the edge that completes EOP_CYC+1 silent cycles in a row.
- R6: While valid, the normal-threshold flags have no effect. A normal flag without a reduced flag does not hold off end of packet.
- R7: `thr_sel_o[0]` is 1 (reduced thresholds) exactly while `data_valid_o` is high. It returns to 0 (normal thresholds) at end of packet. It is 0 after reset.
- R8: `thr_sel_o[1]` follows `long_cable_i`, which requests the lowered threshold set. By default this path has no register.
- R9: A candidate dropped on a window failure restarts at once if a normal crossing is present on that same failing edge. The reference polarity is then taken from that crossing.
- R10: While `rst_n` is low, `data_valid_o` and `thr_sel_o[0]` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_hi_i | input | 1 | Positive crossing of the normal threshold |
| neg_hi_i | input | 1 | Negative crossing of the normal threshold |
| pos_lo_i | input | 1 | Positive crossing of the reduced threshold |
| neg_lo_i | input | 1 | Negative crossing of the reduced threshold |
| long_cable_i | input | 1 | Configuration: request the lowered threshold set |
| data_valid_o | output | 1 | Qualified receive data present |
| thr_sel_o | output | 2 | Bit 0: reduced thresholds in use; bit 1: lowered (long-cable) set |

## Verification
The bench probes the exact window edges. An opposite or returning crossing on the WIN_CYC-th edge must be accepted, and one on the next edge must not. A design that is off by one there would accept late pulses or refuse legal ones. End of packet is tested with silences of exactly EOP_CYC cycles, which must not end the packet, and of EOP_CYC+1, which must. A wrong count would make data-valid drop early or linger. Further cases cover a crossing that lands on a failing edge and must restart the sequence, a tie between polarities, and normal-threshold pulses during a packet that must be ignored. A design that got these wrong would swallow a real preamble or hold a dead packet open.

// File: rtl/sq_pkg.sv
package sq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_OPP  = 2'd1,
      SQ_ORIG = 2'd2,
      SQ_DATA = 2'd3
   } sq_state_e;

   typedef struct packed {
      logic pos;
      logic neg;
   } sq_xing_t;

endpackage

// File: rtl/sq_xing_sel.sv
module sq_xing_sel #(
   parameter bit POS_PRIO = 1'b1
) (
   input  sq_pkg::sq_xing_t hi_x,
   input  sq_pkg::sq_xing_t lo_x,
   output logic             start_vld,
   output logic             start_pos,
   output logic             lo_any
);

   assign start_vld = hi_x.pos | hi_x.neg;
   assign lo_any    = lo_x.pos | lo_x.neg;

   generate
      if (POS_PRIO) begin : g_pos_first
         assign start_pos = hi_x.pos;
      end else begin : g_neg_first
         assign start_pos = hi_x.pos & ~hi_x.neg;
      end
   endgenerate

endmodule

// File: rtl/sq_timer.sv
module sq_timer #(
   parameter int LIM = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic at_lim
);

   localparam int CW = (LIM < 1) ? 1 : $clog2(LIM + 1);
   localparam logic [CW-1:0] LIM_V = CW'(LIM);

   generate
      if (LIM < 1) begin : g_bad_lim
         $error("sq_timer: LIM must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (en && cnt_q != LIM_V) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign at_lim = (cnt_q == LIM_V);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM_V); // R2

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/sq_fsm.sv
module sq_fsm
   import sq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pos_hi,
   input  logic neg_hi,
   input  logic start_vld,
   input  logic start_pos,
   input  logic lo_any,
   input  logic win_lim,
   input  logic eop_lim,
   output logic win_clr,
   output logic eop_clr,
   output logic valid
);

   sq_state_e st_q, st_n;
   logic      ref_pos_q, ref_pos_n;
   logic      restart;
   logic      opp_x, orig_x;

   assign opp_x  = ref_pos_q ? neg_hi : pos_hi;
   assign orig_x = ref_pos_q ? pos_hi : neg_hi;

   always_comb begin
      st_n      = st_q;
      ref_pos_n = ref_pos_q;
      restart   = 1'b0;
      unique case (st_q)
         SQ_IDLE: begin
            if (start_vld) begin
               st_n      = SQ_OPP;
               ref_pos_n = start_pos;
            end
         end
         SQ_OPP: begin
            if (opp_x) begin
               st_n = SQ_ORIG;
            end else if (win_lim) begin
               if (start_vld) begin
                  restart   = 1'b1;
                  ref_pos_n = start_pos;
                  st_n      = SQ_OPP;
               end else begin
                  st_n = SQ_IDLE;
               end
            end
         end
         SQ_ORIG: begin
            if (orig_x) begin
               st_n = SQ_DATA;
            end else if (win_lim) begin
               if (start_vld) begin
                  restart   = 1'b1;
                  ref_pos_n = start_pos;
                  st_n      = SQ_OPP;
               end else begin
                  st_n = SQ_IDLE;
               end
            end
         end
         SQ_DATA: begin
            if (!lo_any && eop_lim) begin
               st_n = SQ_IDLE;
            end
         end
         default: st_n = SQ_IDLE;
      endcase
   end

   assign win_clr = restart || (st_n != st_q) || !(st_q inside {SQ_OPP, SQ_ORIG});
   assign eop_clr = (st_q != SQ_DATA) || lo_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         ref_pos_q <= 1'b1;
      end else begin
         st_q      <= st_n;
         ref_pos_q <= ref_pos_n;
      end
   end

   assign valid = (st_q == SQ_DATA);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_IDLE && !pos_hi && !neg_hi) |=> (st_q == SQ_IDLE)); // R1

   AST_OPP_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_OPP && win_lim && !opp_x) |=> (st_q inside {SQ_IDLE, SQ_OPP})); // R2

   AST_ORIG_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_ORIG && win_lim && !orig_x) |=> (st_q != SQ_DATA)); // R3

   AST_VALID_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == SQ_DATA) |-> $past(st_q == SQ_ORIG)); // R4

   AST_EOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_DATA && lo_any) |=> (st_q == SQ_DATA)); // R5

   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_OPP && win_lim && !opp_x && start_vld) |=> (st_q == SQ_OPP)); // R9

endmodule

// File: rtl/squelch_qualifier.sv
module squelch_qualifier #(
   parameter int WIN_CYC      = 15,
   parameter int EOP_CYC      = 20,
   parameter bit POS_PRIO     = 1'b1,
   parameter bit LONG_SEL_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pos_hi_i,
   input  logic       neg_hi_i,
   input  logic       pos_lo_i,
   input  logic       neg_lo_i,
   input  logic       long_cable_i,
   output logic       data_valid_o,
   output logic [1:0] thr_sel_o
);

   localparam int WIN_LIM = WIN_CYC - 1;
   localparam int EOP_LIM = EOP_CYC;

   generate
      if (WIN_CYC < 2) begin : g_bad_win
         $error("squelch_qualifier: WIN_CYC must be at least 2");
      end
      if (EOP_CYC < 1) begin : g_bad_eop
         $error("squelch_qualifier: EOP_CYC must be at least 1");
      end
   endgenerate

   sq_pkg::sq_xing_t hi_x, lo_x;
   logic start_vld, start_pos, lo_any;
   logic win_clr, eop_clr, win_lim, eop_lim;
   logic valid;

   assign hi_x = '{pos: pos_hi_i, neg: neg_hi_i};
   assign lo_x = '{pos: pos_lo_i, neg: neg_lo_i};

   sq_xing_sel #(.POS_PRIO(POS_PRIO)) u_sel (
      .hi_x      (hi_x),
      .lo_x      (lo_x),
      .start_vld (start_vld),
      .start_pos (start_pos),
      .lo_any    (lo_any)
   );

   sq_timer #(.LIM(WIN_LIM)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (win_clr),
      .en     (1'b1),
      .at_lim (win_lim)
   );

   sq_timer #(.LIM(EOP_LIM)) u_eop (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (eop_clr),
      .en     (1'b1),
      .at_lim (eop_lim)
   );

   sq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pos_hi    (pos_hi_i),
      .neg_hi    (neg_hi_i),
      .start_vld (start_vld),
      .start_pos (start_pos),
      .lo_any    (lo_any),
      .win_lim   (win_lim),
      .eop_lim   (eop_lim),
      .win_clr   (win_clr),
      .eop_clr   (eop_clr),
      .valid     (valid)
   );

   assign data_valid_o = valid;
   assign thr_sel_o[0] = valid;

   generate
      if (LONG_SEL_REG) begin : g_long_reg
         logic long_q;
         always_ff @(posedge clk) begin
            if (!rst_n) long_q <= 1'b0;
            else        long_q <= long_cable_i;
         end
         assign thr_sel_o[1] = long_q;
      end else begin : g_long_comb
         assign thr_sel_o[1] = long_cable_i;
      end
   endgenerate

   AST_SEL_TRACKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_valid_o) |-> !thr_sel_o[0]); // R7

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(!rst_n) |-> (!data_valid_o && !thr_sel_o[0])); // R10

endmodule

// File: tb/tb_squelch_qualifier.sv
`timescale 1ns/1ps
module tb_squelch_qualifier;

   localparam int WIN = 15;
   localparam int EOP = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ph = 1'b0, nh = 1'b0, pl = 1'b0, nl = 1'b0, lc = 1'b0;
   logic dv;
   logic [1:0] sel;

   always #4 clk = ~clk;

   squelch_qualifier #(.WIN_CYC(WIN), .EOP_CYC(EOP)) dut (
      .clk (clk), .rst_n (rst_n),
      .pos_hi_i (ph), .neg_hi_i (nh), .pos_lo_i (pl), .neg_lo_i (nl),
      .long_cable_i (lc),
      .data_valid_o (dv), .thr_sel_o (sel)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;
   string cur_req = "R10";

   // behavioural reference: phase 0 idle, 1 want opposite, 2 want return, 3 data
   int m_ph = 0;
   bit m_ref = 1'b1;
   int m_age = 0;

   task automatic try_start();
      if (ph) begin m_ph = 1; m_ref = 1'b1; m_age = 0; end
      else if (nh) begin m_ph = 1; m_ref = 1'b0; m_age = 0; end
      else m_ph = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_ref = 1'b1; m_age = 0;
      end else begin
         case (m_ph)
            0: try_start();
            1: begin
               m_age++;
               if ((m_ref ? nh : ph) && m_age <= WIN) begin m_ph = 2; m_age = 0; end
               else if (m_age >= WIN) try_start();
            end
            2: begin
               m_age++;
               if ((m_ref ? ph : nh) && m_age <= WIN) begin m_ph = 3; m_age = 0; end
               else if (m_age >= WIN) try_start();
            end
            default: begin
               if (pl || nl) m_age = 0;
               else m_age++;
               if (m_age > EOP) begin m_ph = 0; m_age = 0; end
            end
         endcase
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, "data_valid", int'(dv), int'(m_ph == 3));
         chk("R7", "thr_sel[0]", int'(sel[0]), int'(m_ph == 3));
         chk("R8", "thr_sel[1]", int'(sel[1]), int'(lc));
      end
   end

   // f = {pos_hi, neg_hi, pos_lo, neg_lo}
   localparam logic [3:0] QT = 4'b0000, PH = 4'b1010, NH = 4'b0101;

   task automatic drv(input logic [3:0] f, input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk); #1;
         {ph, nh, pl, nl} = f;
      end
   endtask

   task automatic open_pkt();
      drv(PH, 1); drv(QT, 3); drv(NH, 1); drv(QT, 3); drv(PH, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10", "valid in reset", int'(dv), 0);
      chk("R10", "sel0 in reset", int'(sel[0]), 0);
      @(negedge clk); #1; rst_n = 1'b1;

      cur_req = "R1";
      drv(4'b0010, 5); drv(4'b0001, 5); drv(QT, 10);
      drv(PH, 1); drv(QT, 30);
      drv(4'b1111, 1); drv(NH, 1); drv(PH, 1); drv(QT, 30);

      cur_req = "R4";
      open_pkt(); drv(4'b0010, 5); drv(QT, 30);
      drv(NH, 2); drv(PH, 2); drv(NH, 2); drv(QT, 30);

      cur_req = "R2";
      drv(PH, 1); drv(QT, WIN - 1); drv(NH, 1); drv(QT, 3); drv(PH, 1); drv(QT, 30);
      drv(PH, 1); drv(QT, WIN); drv(NH, 1); drv(QT, 40);

      cur_req = "R3";
      drv(NH, 1); drv(QT, 2); drv(PH, 1); drv(QT, WIN - 1); drv(NH, 1); drv(QT, 30);
      drv(NH, 1); drv(QT, 2); drv(PH, 1); drv(QT, WIN); drv(NH, 1); drv(QT, 40);

      cur_req = "R5";
      open_pkt();
      drv(QT, EOP); drv(4'b0001, 1); drv(QT, EOP); drv(4'b0010, 1); drv(QT, EOP + 1);
      drv(QT, 5);

      cur_req = "R6";
      open_pkt(); drv(4'b1000, 15); drv(4'b0100, 15); drv(QT, 10);

      cur_req = "R8";
      lc = 1'b1; open_pkt(); drv(4'b0010, 4); lc = 1'b0; drv(QT, 30); lc = 1'b1; drv(QT, 3);
      lc = 1'b0;

      cur_req = "R9";
      drv(PH, 1); drv(QT, WIN - 1); drv(NH, 1); drv(QT, 2); drv(PH, 1); drv(QT, 30);
      drv(PH, 1); drv(QT, WIN - 1); drv(PH, 1); drv(NH, 1); drv(PH, 1); drv(QT, 30);
      drv(NH, 1); drv(PH, 1); drv(QT, WIN - 1); drv(PH, 1); drv(NH, 1); drv(PH, 1); drv(QT, 30);

      cur_req = "R10";
      open_pkt(); drv(4'b0010, 2);
      @(negedge clk); #1; rst_n = 1'b0;
      @(negedge clk);
      chk("R10", "valid after mid-packet reset", int'(dv), 0);
      #1; rst_n = 1'b1;
      drv(QT, 5);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule